// File: doc/BRIEF.md
# Fractional Resampling Phase Accumulator

This block produces the timing controls for a fractional downsampler. It holds a ratio word with 2 integer bits and 30 fraction bits. The ratio is the input rate divided by the output rate, and it is meant to lie between 1 and 4. The block adds this ratio into a phase accumulator once for every output sample. The carry out of the fraction tells how many further input samples to pass over before the next output sample. The phase that was held before the add is given out as a 12-bit delay word. A downstream interpolation filter uses that word to choose a coefficient set.

The block sees one input sample per cycle on which `in_valid` is high. On an input sample where no skips remain, the block registers one output record. The record carries `out_valid`, the delay word and the new skip count. On each input sample that is passed over, the pending skip count counts down by one.

A signed correction word can be added to the user ratio, for example by a rate-tracking loop. When the correction path is disabled, the ratio goes into the accumulator unchanged. A synchronous clear returns the phase and the skip count to zero.

Top module: `frac_delay_acc`

## Requirements
- R1: While reset is held, and on the first cycles after it is released, `out_valid`, `out_delay` and `out_skip` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, `clr` low and a pending skip count of zero. It is low in every other cycle.
- R3: `out_delay` is bits 29..18 of the phase held before the add. The phase is the 30-bit fraction of the accumulator.
- R4: `out_skip` equals the integer part of (phase + effective ratio) minus one. The integer part is the sum shifted right by 30. For example, a ratio of 1.0 (0x4000_0000) gives a skip of 0 on every input.
- R5: After each add, the accumulator keeps only the 30 fraction bits; the integer part is used up as the skip count.
- R6: When `corr_en` is 0, the effective ratio equals `ratio` exactly, whatever value `corr` holds.
- R7: When `corr_en` is 1, the effective ratio is `ratio` plus the two's-complement value of `corr`, saturated to the range 0 to 0xFFFF_FFFF.
- R8: When the integer part of the sum is 0 (a ratio below 1.0), the skip count is 0.
- R9: `clr` high sets the phase, the pending skip count and all outputs to zero in the next cycle, and it overrides `in_valid`.
- R10: In a cycle with `in_valid` and `clr` both low, the phase and the pending skip count hold, and `out_valid` goes low in the next cycle. `out_delay` and `out_skip` hold.
- R11: Each input sample that arrives while the skip count is nonzero decrements that count by one and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Synchronous clear of the phase and the skip state |
| in_valid | input | 1 | An input sample is present this cycle |
| ratio | input | 32 | User ratio, 2.30 unsigned fixed point |
| corr | input | 32 | Signed ratio correction, same scaling |
| corr_en | input | 1 | Enables the correction path |
| out_valid | output | 1 | The registered output record belongs to an output sample |
| out_delay | output | 12 | Delay word that selects the interpolation phase |
| out_skip | output | 2 | Input samples to pass over before the next output sample |

## Verification
The assertions check the following on every cycle:
- `out_valid` rises only after an accepted input sample, and a pending skip blocks it.
- A clear zeroes the state in the next cycle.
- Idle cycles hold the state.
- A positive correction never lowers the effective ratio, and a negative one never raises it.

The arithmetic itself can be shown only by the bench's reference model. That covers the delay word drawn from the old phase, the carry turned into a skip count, the kept fraction, and saturation at both ends. The bench checks it across long random runs and directed runs at ratios of 1.0, just under 4.0 and below 1.0.

// File: rtl/frac_acc_pkg.sv
package frac_acc_pkg;
  localparam int unsigned RATIO_W_DEF = 32;
  localparam int unsigned INT_W_DEF   = 2;
  localparam int unsigned DELAY_W_DEF = 12;
  localparam int unsigned CORR_W_DEF  = 32;
endpackage

// File: rtl/frac_rst_sync.sv
module frac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/frac_ratio_merge.sv
module frac_ratio_merge #(
  parameter int unsigned RATIO_W = frac_acc_pkg::RATIO_W_DEF,
  parameter int unsigned CORR_W  = frac_acc_pkg::CORR_W_DEF
) (
  input  logic [RATIO_W-1:0] ratio,
  input  logic [CORR_W-1:0]  corr,
  input  logic               corr_en,
  output logic [RATIO_W-1:0] step
);
  localparam int unsigned SUM_W = RATIO_W + 2;

  logic [SUM_W-1:0] ext_ratio;
  logic [SUM_W-1:0] ext_corr;
  logic [SUM_W-1:0] raw_sum;

  always_comb begin
    ext_ratio = {2'b00, ratio};
    ext_corr  = {{(SUM_W-CORR_W){corr[CORR_W-1]}}, corr};
    raw_sum   = ext_ratio + ext_corr;
    if (!corr_en)                step = ratio;
    else if (raw_sum[SUM_W-1])   step = '0;
    else if (raw_sum[SUM_W-2])   step = '1;
    else                         step = raw_sum[RATIO_W-1:0];
  end

  always_comb begin
    if (corr_en && !corr[CORR_W-1]) begin
      // R7
      pos_corr_no_drop_chk: assert (step >= ratio);
    end
    if (corr_en && corr[CORR_W-1]) begin
      // R7
      neg_corr_no_rise_chk: assert (step <= ratio);
    end
  end
endmodule

// File: rtl/frac_phase_core.sv
module frac_phase_core #(
  parameter int unsigned RATIO_W = frac_acc_pkg::RATIO_W_DEF,
  parameter int unsigned INT_W   = frac_acc_pkg::INT_W_DEF,
  parameter int unsigned DELAY_W = frac_acc_pkg::DELAY_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               in_valid,
  input  logic [RATIO_W-1:0] step,
  output logic               out_valid,
  output logic [DELAY_W-1:0] out_delay,
  output logic [INT_W-1:0]   out_skip
);
  localparam int unsigned FRAC_W = RATIO_W - INT_W;
  localparam int unsigned ACC_W  = RATIO_W + 1;
  localparam int unsigned CAR_W  = INT_W + 1;

  logic [FRAC_W-1:0]  phase_q, phase_d;
  logic [INT_W-1:0]   skip_q, skip_d;
  logic               ov_q, ov_d;
  logic [DELAY_W-1:0] od_q, od_d;
  logic [INT_W-1:0]   os_q, os_d;
  logic               upd_en;
  logic               take;
  logic [ACC_W-1:0]   sum;
  logic [CAR_W-1:0]   carry;
  logic [CAR_W-1:0]   carry_m1;
  logic [INT_W-1:0]   skip_calc;

  always_comb begin
    take      = in_valid && (skip_q == '0);
    sum       = {1'b0, step} + {{CAR_W{1'b0}}, phase_q};
    carry     = sum[ACC_W-1:FRAC_W];
    carry_m1  = carry - CAR_W'(1);
    skip_calc = (carry == '0) ? '0 : carry_m1[INT_W-1:0];
  end

  always_comb begin
    phase_d = phase_q;
    skip_d  = skip_q;
    ov_d    = 1'b0;
    od_d    = od_q;
    os_d    = os_q;
    if (clr) begin
      phase_d = '0;
      skip_d  = '0;
      od_d    = '0;
      os_d    = '0;
    end else if (take) begin
      phase_d = sum[FRAC_W-1:0];
      skip_d  = skip_calc;
      ov_d    = 1'b1;
      od_d    = phase_q[FRAC_W-1 -: DELAY_W];
      os_d    = skip_calc;
    end else if (in_valid) begin
      skip_d  = skip_q - INT_W'(1);
    end
    upd_en = clr | in_valid | ov_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      skip_q  <= '0;
      ov_q    <= 1'b0;
      od_q    <= '0;
      os_q    <= '0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      skip_q  <= skip_d;
      ov_q    <= ov_d;
      od_q    <= od_d;
      os_q    <= os_d;
    end
  end

  assign out_valid = ov_q;
  assign out_delay = od_q;
  assign out_skip  = os_q;

  // R2
  out_valid_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> $past(in_valid && !clr));

  // R11
  pending_skip_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr && skip_q != '0) |=> !ov_q);

  // R9
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ov_q && phase_q == '0 && skip_q == '0));

  // R10
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> ($stable(phase_q) && $stable(skip_q) && !ov_q));
endmodule

// File: rtl/frac_delay_acc.sv
module frac_delay_acc #(
  parameter int unsigned RATIO_W = frac_acc_pkg::RATIO_W_DEF,
  parameter int unsigned INT_W   = frac_acc_pkg::INT_W_DEF,
  parameter int unsigned DELAY_W = frac_acc_pkg::DELAY_W_DEF,
  parameter int unsigned CORR_W  = frac_acc_pkg::CORR_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               in_valid,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [CORR_W-1:0]  corr,
  input  logic               corr_en,
  output logic               out_valid,
  output logic [DELAY_W-1:0] out_delay,
  output logic [INT_W-1:0]   out_skip
);
  logic               rst_n_s;
  logic [RATIO_W-1:0] step;

  frac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  frac_ratio_merge #(.RATIO_W(RATIO_W), .CORR_W(CORR_W)) u_merge (
    .ratio   (ratio),
    .corr    (corr),
    .corr_en (corr_en),
    .step    (step)
  );

  frac_phase_core #(.RATIO_W(RATIO_W), .INT_W(INT_W), .DELAY_W(DELAY_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (clr),
    .in_valid  (in_valid),
    .step      (step),
    .out_valid (out_valid),
    .out_delay (out_delay),
    .out_skip  (out_skip)
  );
endmodule

// File: tb/test_frac_delay_acc.sv
module test_frac_delay_acc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr;
  logic        in_valid;
  logic [31:0] ratio;
  logic [31:0] corr;
  logic        corr_en;
  logic        out_valid;
  logic [11:0] out_delay;
  logic [1:0]  out_skip;

  int n_vec = 0;
  int n_bad = 0;

  logic [29:0] m_phase;
  logic [1:0]  m_skip;
  logic        e_valid;
  logic [11:0] e_delay;
  logic [1:0]  e_skip;

  frac_delay_acc i_frac_delay_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .ratio(ratio), .corr(corr), .corr_en(corr_en),
    .out_valid(out_valid), .out_delay(out_delay), .out_skip(out_skip)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] bench_eff(logic [31:0] r, logic [31:0] c, logic en);
    longint s;
    if (!en) return r;
    s = longint'(r) + longint'($signed(c));
    if (s < 0) return 32'h0;
    if (s > 64'sh0_FFFF_FFFF) return 32'hFFFF_FFFF;
    return s[31:0];
  endfunction

  task automatic model_step();
    longint sum;
    longint ip;
    logic [31:0] eff;
    eff = bench_eff(ratio, corr, corr_en);
    if (clr) begin
      m_phase = '0; m_skip = '0; e_valid = 0; e_delay = '0; e_skip = '0;
    end else if (in_valid && m_skip == 0) begin
      sum = longint'(m_phase) + longint'(eff);
      ip  = sum >>> 30;
      e_valid = 1;
      e_delay = m_phase[29:18];
      e_skip  = (ip == 0) ? 2'd0 : 2'(ip - 1);
      m_skip  = e_skip;
      m_phase = sum[29:0];
    end else if (in_valid) begin
      m_skip  = m_skip - 2'd1;
      e_valid = 0;
    end else begin
      e_valid = 0;
    end
  endtask

  task automatic check(string tag);
    n_vec++;
    if (out_valid !== e_valid) begin
      n_bad++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, e_valid);
    end
    n_vec++;
    if (out_delay !== e_delay) begin
      n_bad++;
      $display("FAIL %s out_delay actual=%03h expected=%03h", tag, out_delay, e_delay);
    end
    n_vec++;
    if (out_skip !== e_skip) begin
      n_bad++;
      $display("FAIL %s out_skip actual=%0d expected=%0d", tag, out_skip, e_skip);
    end
  endtask

  task automatic apply(logic c, logic v, logic [31:0] r, logic [31:0] k, logic en, string tag);
    clr = c; in_valid = v; ratio = r; corr = k; corr_en = en;
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [31:0] rnd_ratio();
    return 32'h4000_0000 + ($urandom % 32'hC000_0000);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; clr = 0; in_valid = 0; ratio = 32'h4000_0000; corr = '0; corr_en = 0;
    m_phase = '0; m_skip = '0; e_valid = 0; e_delay = '0; e_skip = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1 after release");
    end

    // R4: ratio exactly 1.0 -> output every input, skip 0
    for (int i = 0; i < 20; i++) apply(0, 1, 32'h4000_0000, '0, 0, "R4 unity");
    // R4/R5: ratio just under 4.0
    for (int i = 0; i < 40; i++) apply(0, 1, 32'hFFFF_FFFF, '0, 0, "R4 R5 max ratio");
    // R2 R3 R4 R5 R11: main random run
    for (int i = 0; i < 4000; i++)
      apply(0, ($urandom % 5) != 0, rnd_ratio(), $urandom, 0, "R2 R3 R4 R5 R11 random");
    // R6: correction disabled, corr varies freely
    for (int i = 0; i < 600; i++)
      apply(0, 1, rnd_ratio(), $urandom, 0, "R6 corr disabled");
    // R7: correction enabled, including both saturation ends
    for (int i = 0; i < 300; i++)
      apply(0, 1, 32'hFFFF_0000 + ($urandom % 32'h1_0000), 32'h0010_0000 + ($urandom % 32'h100_0000), 1, "R7 high saturation");
    for (int i = 0; i < 300; i++)
      apply(0, 1, $urandom % 32'h100_0000, 32'h8000_0000 + ($urandom % 32'h1000_0000), 1, "R7 low saturation");
    for (int i = 0; i < 1200; i++)
      apply(0, ($urandom % 4) != 0, rnd_ratio(), $urandom, 1, "R7 corr enabled");
    // R8: ratio below 1.0
    for (int i = 0; i < 600; i++)
      apply(0, ($urandom % 3) != 0, $urandom % 32'h4000_0000, '0, 0, "R8 sub-unity");
    // R9: clears mixed with traffic, clear with in_valid high
    for (int i = 0; i < 1000; i++)
      apply(($urandom % 8) == 0, ($urandom % 4) != 0, rnd_ratio(), '0, 0, "R9 clear");
    apply(1, 1, 32'hFFFF_FFFF, '0, 0, "R9 clear over input");
    // R10: sparse input samples
    for (int i = 0; i < 800; i++)
      apply(0, ($urandom % 4) == 0, rnd_ratio(), '0, 0, "R10 idle hold");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule